// File: doc/BRIEF.md
# Multiplexed Host Bus Slave Port

This block lets an external host processor read and write a small bank of data registers through a shared address/data bus. A host transaction has two phases. First the host raises an address-latch strobe, puts a register address on the shared bus and drops the strobe; the port keeps that address. Then the host sets a read/write line and raises a data strobe together with a chip select. The port acknowledges. On a read it drives the addressed register onto the bus. On a write the host supplies data after the acknowledge, and the port stores it when the strobes end. After the strobes end, the port drops its acknowledge and stops driving the bus.

The host signals arrive without timing relation to the core clock. They pass through a two-stage synchroniser, together with a delayed copy of the bus, before any edge detection. The core side has a plain register port. It can write any register in one clock and read any register combinationally. All host strobes are active high, and the shared bus is split into an input, an output and an output enable.

Top module: `hbp_port`

## Requirements
- R1: After reset, `host_ack_o` and `host_ad_oe_o` are 0, the latched register index is 0, and every data register reads 0 on the core port.
- R2: The register index is taken from the shared bus as it stood when the address-latch strobe `host_ale_i` fell. Later changes on the bus do not alter it until the next falling edge of that strobe.
- R3: Only bits [2:0] of the latched bus value select one of the 8 registers. Bits [DW-1:3] are ignored, so address 8*k+n selects register n.
- R4: A transfer starts only when `host_ds_i` and `host_cs_i` are both 1. After both rise together at an input, `host_ack_o` rises on the third rising clock edge and is still 0 after the second. If only one of the two is 1, `host_ack_o` stays 0.
- R5: In a read transfer (`host_rnw_i` = 1 when the strobes start), while `host_ack_o` is 1, `host_ad_oe_o` is 1 and `host_ad_o` equals the addressed register.
- R6: In a write transfer (`host_rnw_i` = 0), `host_ad_oe_o` stays 0. The bus value present as the strobes end is stored into the addressed register. It is visible on the core port after the fourth rising edge that follows the strobes' fall.
- R7: After the strobes fall, `host_ack_o` and `host_ad_oe_o` return to 0 on the third rising clock edge.
- R8: When `core_we_i` is 1 at a rising edge, `core_wdata_i` is stored in register `core_idx_i`. `core_rdata_o` shows register `core_idx_i` combinationally.
- R9: If a host write and a core write target the same register in the same clock, the register takes the host data. If they target different registers, both registers are updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_ale_i | input | 1 | Address-latch strobe, active high |
| host_rnw_i | input | 1 | 1 = read, 0 = write |
| host_ds_i | input | 1 | Data strobe, active high |
| host_cs_i | input | 1 | Chip select, active high |
| host_ad_i | input | DW | Shared bus, value driven by the host |
| host_ad_o | output | DW | Shared bus, value driven by the port |
| host_ad_oe_o | output | 1 | Port drives the shared bus |
| host_ack_o | output | 1 | Transfer acknowledge |
| core_we_i | input | 1 | Core register write enable |
| core_idx_i | input | IDX_W | Core register index |
| core_wdata_i | input | DW | Core write data |
| core_rdata_o | output | DW | Core read data |

## Verification
The bench checks the exact clock edges at which the acknowledge rises and falls. A design with a missing or extra synchroniser stage shows up as an off-by-one edge. It moves the bus away right after the latch strobe falls, so a design that samples the address late or keeps tracking the bus reads or writes the wrong register. It raises a lone data strobe and a lone chip select, which catches an OR where an AND belongs. It also lines up a core write to the same register in the very cycle the host write commits, which exposes an inverted priority. Aliased high address bits and a random mix of host and core traffic, compared against a bench model, cover the rest.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    typedef enum logic {
        HB_IDLE = 1'b0,
        HB_BUSY = 1'b1
    } hb_state_e;

endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign stage_d[s] = async_i;
        end else begin : g_next
            assign stage_d[s] = stage_q[s-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hbp_ctrl.sv
module hbp_ctrl
    import hbp_pkg::*;
#(
    parameter int DW    = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ale_s,
    input  logic             rnw_s,
    input  logic             ds_s,
    input  logic             cs_s,
    input  logic [DW-1:0]    ad_s,
    output logic [IDX_W-1:0] idx_o,
    output logic             ack_o,
    output logic             oe_o,
    output logic             hwe_o,
    output logic [DW-1:0]    hdata_o
);
    typedef struct packed {
        hb_state_e        state;
        logic             ale_prev;
        logic [IDX_W-1:0] idx;
        logic             ack;
        logic             rd;
        logic             hwe;
        logic [DW-1:0]    hdata;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  strobe;
    logic  ale_fall;

    assign strobe   = ds_s & cs_s;
    assign ale_fall = st_q.ale_prev & ~ale_s;

    always_comb begin
        st_d          = st_q;
        st_d.hwe      = 1'b0;
        st_d.ale_prev = ale_s;
        if (ale_fall) begin
            st_d.idx = ad_s[IDX_W-1:0];
        end
        unique case (st_q.state)
            HB_IDLE: begin
                if (strobe) begin
                    st_d.state = HB_BUSY;
                    st_d.ack   = 1'b1;
                    st_d.rd    = rnw_s;
                end
            end
            HB_BUSY: begin
                if (!strobe) begin
                    st_d.state = HB_IDLE;
                    st_d.ack   = 1'b0;
                    if (!st_q.rd) begin
                        st_d.hwe   = 1'b1;
                        st_d.hdata = ad_s;
                    end
                end
            end
            default: st_d.state = HB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: HB_IDLE, ale_prev: 1'b0, idx: '0, ack: 1'b0,
                      rd: 1'b0, hwe: 1'b0, hdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o   = st_q.idx;
    assign ack_o   = st_q.ack;
    assign oe_o    = st_q.ack & st_q.rd;
    assign hwe_o   = st_q.hwe;
    assign hdata_o = st_q.hdata;

    logic [IDX_W-1:0] idx_q;
    logic             ack_q;
    logic             hwe_q;
    assign idx_q = st_q.idx;
    assign ack_q = st_q.ack;
    assign hwe_q = st_q.hwe;

    // R4: acknowledge only rises in answer to both strobes
    assert_ack_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> $past(strobe));

    // R7: acknowledge only falls once the strobes have ended
    assert_ack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_q) |-> !$past(strobe));

    // R2: latched index only moves after a latch-strobe falling edge
    assert_idx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(idx_q) |-> $past(ale_fall));

    // R6: one commit per host write, never while acknowledging
    assert_single_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hwe_q |=> !hwe_q && !ack_q);
endmodule

// File: rtl/hbp_regs.sv
module hbp_regs #(
    parameter int DW    = 16,
    parameter int NREG  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hwe_i,
    input  logic [IDX_W-1:0] hidx_i,
    input  logic [DW-1:0]    hdata_i,
    input  logic             cwe_i,
    input  logic [IDX_W-1:0] cidx_i,
    input  logic [DW-1:0]    cdata_i,
    output logic [DW-1:0]    hrd_o,
    output logic [DW-1:0]    crd_o
);
    logic [DW-1:0] regs_d [NREG];
    logic [DW-1:0] regs_q [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic host_hit;
        logic core_hit;
        assign host_hit = hwe_i && (hidx_i == IDX_W'(r));
        assign core_hit = cwe_i && (cidx_i == IDX_W'(r));
        assign regs_d[r] = host_hit ? hdata_i :
                           core_hit ? cdata_i : regs_q[r];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[r] <= '0;
            end else begin
                regs_q[r] <= regs_d[r];
            end
        end
    end

    assign hrd_o = regs_q[hidx_i];
    assign crd_o = regs_q[cidx_i];

    // R9: host data wins a same-register collision
    assert_host_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hwe_i && cwe_i && hidx_i == cidx_i) |=> regs_q[$past(hidx_i)] == $past(hdata_i));

    // R8: a lone core write lands
    assert_core_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cwe_i && !(hwe_i && hidx_i == cidx_i)) |=> regs_q[$past(cidx_i)] == $past(cdata_i));
endmodule

// File: rtl/hbp_port.sv
module hbp_port #(
    parameter int DW    = 16,
    parameter int NREG  = 8,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_ale_i,
    input  logic             host_rnw_i,
    input  logic             host_ds_i,
    input  logic             host_cs_i,
    input  logic [DW-1:0]    host_ad_i,
    output logic [DW-1:0]    host_ad_o,
    output logic             host_ad_oe_o,
    output logic             host_ack_o,
    input  logic             core_we_i,
    input  logic [IDX_W-1:0] core_idx_i,
    input  logic [DW-1:0]    core_wdata_i,
    output logic [DW-1:0]    core_rdata_o
);
    localparam int BW = DW + 4;

    logic [BW-1:0]    bundle_raw;
    logic [BW-1:0]    bundle_s;
    logic             ale_s, rnw_s, ds_s, cs_s;
    logic [DW-1:0]    ad_s;
    logic [IDX_W-1:0] hidx;
    logic             hwe;
    logic [DW-1:0]    hdata;

    assign bundle_raw = {host_ale_i, host_rnw_i, host_ds_i, host_cs_i, host_ad_i};

    hbp_sync #(.W(BW), .STAGES(2)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (bundle_raw),
        .sync_o  (bundle_s)
    );

    assign {ale_s, rnw_s, ds_s, cs_s, ad_s} = bundle_s;

    hbp_ctrl #(.DW(DW), .IDX_W(IDX_W)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ale_s   (ale_s),
        .rnw_s   (rnw_s),
        .ds_s    (ds_s),
        .cs_s    (cs_s),
        .ad_s    (ad_s),
        .idx_o   (hidx),
        .ack_o   (host_ack_o),
        .oe_o    (host_ad_oe_o),
        .hwe_o   (hwe),
        .hdata_o (hdata)
    );

    hbp_regs #(.DW(DW), .NREG(NREG), .IDX_W(IDX_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hwe_i   (hwe),
        .hidx_i  (hidx),
        .hdata_i (hdata),
        .cwe_i   (core_we_i),
        .cidx_i  (core_idx_i),
        .cdata_i (core_wdata_i),
        .hrd_o   (host_ad_o),
        .crd_o   (core_rdata_o)
    );
endmodule

// File: tb/test_hbp_port.sv
module test_hbp_port;
    localparam int DW = 16;
    localparam int NREG = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ale = 0, rnw = 0, ds = 0, cs = 0;
    logic [DW-1:0] ad_i = '0;
    logic [DW-1:0] ad_o;
    logic oe, ack;
    logic core_we = 0;
    logic [IW-1:0] core_idx = '0;
    logic [DW-1:0] core_wdata = '0;
    logic [DW-1:0] core_rdata;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    logic [DW-1:0] model [NREG];
    logic [IW-1:0] cur_idx = '0;

    always #5 clk = ~clk;

    hbp_port #(.DW(DW), .NREG(NREG)) i_hbp_port (
        .clk(clk), .rst_n(rst_n),
        .host_ale_i(ale), .host_rnw_i(rnw), .host_ds_i(ds), .host_cs_i(cs),
        .host_ad_i(ad_i), .host_ad_o(ad_o), .host_ad_oe_o(oe), .host_ack_o(ack),
        .core_we_i(core_we), .core_idx_i(core_idx), .core_wdata_i(core_wdata),
        .core_rdata_o(core_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            mismatched = mismatched + 1;
            $display("FAIL watchdog: act cycles=%0d exp done earlier", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    function automatic logic [IW-1:0] exp_idx(input logic [DW-1:0] a);
        return a[IW-1:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared = compared + 1;
        if (act !== exp) begin
            mismatched = mismatched + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic host_latch(input logic [DW-1:0] a);
        @(negedge clk); ale = 1; ad_i = a;
        @(negedge clk); ale = 0;
        @(negedge clk); ad_i = DW'($urandom);
        @(negedge clk); ad_i = DW'($urandom);
        cur_idx = exp_idx(a);
    endtask

    task automatic core_write(input logic [IW-1:0] i, input logic [DW-1:0] v);
        @(negedge clk); core_we = 1; core_idx = i; core_wdata = v;
        @(negedge clk); core_we = 0;
        model[i] = v;
    endtask

    task automatic core_check(input logic [IW-1:0] i, input string req);
        @(negedge clk); core_idx = i;
        #1 chk(req, core_rdata, model[i]);
    endtask

    task automatic host_read(input string req);
        @(negedge clk); rnw = 1;
        @(negedge clk); ds = 1; cs = 1;
        repeat (2) @(posedge clk);
        #1 chk("R4 ack not yet", ack, 0);
        @(posedge clk);
        #1 chk("R4 ack third edge", ack, 1);
        chk("R5 oe on read", oe, 1);
        chk(req, ad_o, model[cur_idx]);
        @(negedge clk); ds = 0; cs = 0;
        repeat (2) @(posedge clk);
        #1 chk("R7 ack held", ack, 1);
        @(posedge clk);
        #1 chk("R7 ack released", ack, 0);
        chk("R7 oe released", oe, 0);
        @(negedge clk); rnw = 0;
    endtask

    task automatic host_write(input logic [DW-1:0] v, input logic clash,
                              input logic [IW-1:0] cidx, input logic [DW-1:0] cval);
        @(negedge clk); rnw = 0;
        @(negedge clk); ds = 1; cs = 1;
        repeat (3) @(posedge clk);
        #1 chk("R4 ack on write", ack, 1);
        chk("R6 no drive on write", oe, 0);
        @(negedge clk); ad_i = v;
        @(negedge clk); ds = 0; cs = 0;
        repeat (3) @(posedge clk);
        if (clash) begin
            @(negedge clk); core_we = 1; core_idx = cidx; core_wdata = cval;
            @(posedge clk);
            @(negedge clk); core_we = 0;
            model[cidx] = cval;
        end else begin
            @(posedge clk);
        end
        model[cur_idx] = v;
        @(negedge clk); ad_i = DW'($urandom);
    endtask

    initial begin
        void'($urandom(32'd2971));
        for (int i = 0; i < NREG; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ack", ack, 0);
        chk("R1 oe", oe, 0);
        for (int i = 0; i < NREG; i++) core_check(IW'(i), "R1 reg zero");
        core_write(3'd0, 16'hA5A5);
        host_read("R1 index zero after reset");

        // R8 core writes
        for (int i = 0; i < NREG; i++) core_write(IW'(i), DW'(16'h1100 + i * 16'h0101));
        for (int i = 0; i < NREG; i++) core_check(IW'(i), "R8 core readback");

        // R2 address latched then bus moves
        host_latch(16'h0006);
        host_read("R2 latched index read");
        host_latch(16'h0002);
        host_write(16'hBEEF, 0, '0, '0);
        core_check(3'd2, "R6 host write stored");
        core_check(3'd6, "R2 other reg untouched");

        // R3 high bits ignored
        host_latch(16'hFFF5);
        host_read("R3 alias read");
        host_latch(16'h0A0B);
        host_write(16'h1234, 0, '0, '0);
        core_check(3'd3, "R3 alias write");

        // R4 single strobe ignored
        @(negedge clk); ds = 1; cs = 0;
        repeat (6) @(posedge clk);
        #1 chk("R4 ds alone", ack, 0);
        @(negedge clk); ds = 0; cs = 1;
        repeat (6) @(posedge clk);
        #1 chk("R4 cs alone", ack, 0);
        @(negedge clk); cs = 0;
        repeat (4) @(negedge clk);

        // R9 collisions
        host_latch(16'h0004);
        host_write(16'hC0DE, 1, 3'd4, 16'hDEAD);
        core_check(3'd4, "R9 host wins same reg");
        host_latch(16'h0001);
        host_write(16'h7777, 1, 3'd5, 16'h5555);
        core_check(3'd1, "R9 host reg updated");
        core_check(3'd5, "R9 core reg updated");

        // random mix
        for (int n = 0; n < 60; n++) begin
            int op;
            op = int'($urandom % 4);
            case (op)
                0: core_write(IW'($urandom), DW'($urandom));
                1: begin
                    host_latch(DW'($urandom));
                    host_write(DW'($urandom), 0, '0, '0);
                    core_check(cur_idx, "R6 random host write");
                end
                2: begin
                    host_latch(DW'($urandom));
                    host_read("R5 random host read");
                end
                default: core_check(IW'($urandom), "R8 random core read");
            endcase
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule